// File: doc/BRIEF.md
# Sprite Pixel Colour Lookup Pipeline

This block turns a raster position into a 16-bit colour for a sprite-based display path. For each pixel request it tests every sprite entry that is active on the current line and keeps one covering sprite: the lowest-numbered one. It then works out where the matching texel lies in that sprite's texture and reads a 4-bit palette index from texture memory. Finally it reads the colour from a 64-entry palette RAM, which is split into four sub-palettes of 16 entries. If no sprite covers the pixel, the output is a fixed background colour.

Each sprite entry carries a 16-bit texture pointer. Textures are aligned to 4 bytes, so the two low bits of the pointer are not needed for addressing. Those two bits select the sub-palette instead. Texels are packed two per byte. The pipeline has a fixed depth, so the display side gets each colour a known number of cycles after it asks.

The request port uses valid/ready. A request is taken on any rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops while reset is active and while upload mode is on, and the display side must hold its request until it is taken. The response port has no ready signal, so the consumer must accept each `resp_valid` pulse in the cycle it appears.

The write port also uses valid/ready, and `wr_ready` follows `upload_en`. Outside upload mode, an offered write waits and changes nothing. Upload mode is intended for the vertical blanking interval. The sprite fields only need to be valid in the cycle a request is taken.

Top module: `spr_pix_lookup`

## Requirements
- R1: `req_ready` is high exactly when `rst_n` is high and `upload_en` is low; a request is accepted on a rising edge with `req_valid` and `req_ready` both high.
- R2: For a request accepted at the end of cycle c, `resp_valid` is high for exactly one cycle, cycle c+3, with that request's colour; `resp_valid` is low in every cycle that no accepted request maps to.
- R3: Sprite i covers (x, y) only when `spr_valid[i]` is 1, sx ≤ x < sx+w and sy ≤ y < sy+h (unsigned compares); an entry with its valid bit at 0 never covers a pixel.
- R4: When several sprites cover a pixel, the one with the lowest index is used.
- R5: When no sprite covers a pixel, `resp_colour` equals the parameter `BG_COLOUR` (default 16'h0421).
- R6: With texel offset o = (y−sy)·w + (x−sx), the texel byte address is ({ptr[15:2], 2'b00} + floor(o/2)) modulo `TEX_BYTES` (16384). Texture word address is byte address bits [13:2], and byte lane bits [1:0] pick data bits [8·lane+7 : 8·lane].
- R7: When o is even, the palette index is the byte's bits [3:0] (the left pixel); when o is odd, it is bits [7:4].
- R8: The palette entry read is {ptr[1:0], index}, so sub-palette s occupies entries 16·s to 16·s+15, and the 16-bit entry is the output colour.
- R9: `wr_ready` equals `upload_en`. An accepted write with `wr_sel` = 0 updates texture word `wr_addr`, one byte for each set bit of `wr_be` (bit b covers data bits [8b+7:8b]). With `wr_sel` = 1 it stores `wr_data[15:0]` into palette entry `wr_addr[5:0]`, and `wr_be` is ignored.
- R10: A write offered while `upload_en` is low is not accepted and leaves both memories unchanged.
- R11: During reset and in the three cycles that follow it, `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upload_en | input | 1 | Upload mode: opens the write port, closes the request port |
| req_valid | input | 1 | Pixel request offered |
| req_ready | output | 1 | Pixel request can be taken |
| req_x | input | COORD_W | Raster x of the request |
| req_y | input | COORD_W | Raster y of the request |
| spr_valid | input | N_SPR | Per-entry valid bits |
| spr_x | input | N_SPR*COORD_W | Left edge of each entry, entry i at bits [i*COORD_W +: COORD_W] |
| spr_y | input | N_SPR*COORD_W | Top edge of each entry |
| spr_w | input | N_SPR*DIM_W | Width of each entry |
| spr_h | input | N_SPR*DIM_W | Height of each entry |
| spr_ptr | input | N_SPR*16 | Texture pointer: bits [15:2] word-aligned base, bits [1:0] sub-palette |
| resp_valid | output | 1 | Colour response present |
| resp_colour | output | 16 | Colour of the response |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be taken |
| wr_sel | input | 1 | Write target: 0 texture, 1 palette |
| wr_addr | input | TEX_AW | Texture word address or palette entry |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Texture byte enables |

## Verification
The bench loads texture memory and the palette with arithmetic patterns, then sweeps every pixel of an 80×12 window under three sprite sets. The sets contain overlapping entries, a masked entry that would cover everything, a sprite with an odd width, and pointers whose base runs past the top of texture memory. A design that searched from the high end, honoured an invalid entry, or used ≤ at the right or bottom edge would return a colour on pixels that should show the background, or the colour of the wrong sprite. A design that swapped the nibble order, failed to clear the pointer's low bits, or did not wrap the address would read the wrong texel. The bench also records the exact cycle each response is due, so an extra or missing pipeline stage, or a response during upload, is reported. Writes offered outside upload mode and a partial byte-enable write are checked through a pixel that reads the affected bytes and palette entries.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int PTR_W     = 16;
  localparam int COL_W     = 16;
  localparam int SUB_W     = 2;
  localparam int IDX_W     = 4;
  localparam int PAL_DEPTH = (1 << SUB_W) * (1 << IDX_W);
  localparam int PAL_AW    = SUB_W + IDX_W;
  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;

  typedef enum logic {
    WR_TEX = 1'b0,
    WR_PAL = 1'b1
  } wr_tgt_e;

  // Pull one 4-bit texel out of a texture word.
  function automatic logic [IDX_W-1:0] texel_of(input logic [WORD_W-1:0] word,
                                                input logic [1:0] lane,
                                                input logic hi);
    logic [7:0] b;
    b = word[lane*8 +: 8];
    return hi ? b[7:4] : b[3:0];
  endfunction
endpackage

// File: rtl/spx_cover.sv
module spx_cover #(
  parameter int COORD_W = 10,
  parameter int DIM_W   = 8
) (
  input  logic               valid,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] sx,
  input  logic [COORD_W-1:0] sy,
  input  logic [DIM_W-1:0]   w,
  input  logic [DIM_W-1:0]   h,
  output logic               hit,
  output logic [DIM_W-1:0]   dx,
  output logic [DIM_W-1:0]   dy
);
  logic [COORD_W-1:0] dxf, dyf;
  logic               in_x, in_y;
  logic               unused_hi;

  assign dxf  = x - sx;
  assign dyf  = y - sy;
  assign in_x = (x >= sx) && (dxf < COORD_W'(w));
  assign in_y = (y >= sy) && (dyf < COORD_W'(h));
  assign hit  = valid && in_x && in_y;
  assign dx   = dxf[DIM_W-1:0];
  assign dy   = dyf[DIM_W-1:0];
  assign unused_hi = ^{dxf, dyf};
endmodule

// File: rtl/spx_pick.sv
module spx_pick #(
  parameter int N_SPR = 8
) (
  input  logic [N_SPR-1:0] hit_vec,
  output logic [N_SPR-1:0] win_oh,
  output logic             any_hit
);
  always_comb begin
    logic found;
    found  = 1'b0;
    win_oh = '0;
    for (int i = 0; i < N_SPR; i++) begin
      if (hit_vec[i] && !found) begin
        win_oh[i] = 1'b1;
        found     = 1'b1;
      end
    end
    any_hit = found;
  end
endmodule

// File: rtl/spx_texmem.sv
module spx_texmem #(
  parameter int WORDS = 4096,
  parameter int AW    = 12,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [LANES*8-1:0] wdata,
  input  logic [LANES-1:0]   wbe,
  input  logic               re,
  input  logic [AW-1:0]      raddr,
  output logic [LANES*8-1:0] rdata
);
  logic [LANES*8-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < LANES; b++) begin
        if (wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spx_palram.sv
module spx_palram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spr_pix_lookup.sv
module spr_pix_lookup
  import spx_pkg::*;
#(
  parameter int               N_SPR     = 8,
  parameter int               COORD_W   = 10,
  parameter int               DIM_W     = 8,
  parameter int               TEX_BYTES = 16384,
  parameter logic [COL_W-1:0] BG_COLOUR = 16'h0421,
  localparam int              TEX_AW    = $clog2(TEX_BYTES / LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upload_en,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [COORD_W-1:0]       req_x,
  input  logic [COORD_W-1:0]       req_y,
  input  logic [N_SPR-1:0]         spr_valid,
  input  logic [N_SPR*COORD_W-1:0] spr_x,
  input  logic [N_SPR*COORD_W-1:0] spr_y,
  input  logic [N_SPR*DIM_W-1:0]   spr_w,
  input  logic [N_SPR*DIM_W-1:0]   spr_h,
  input  logic [N_SPR*PTR_W-1:0]   spr_ptr,
  output logic                     resp_valid,
  output logic [COL_W-1:0]         resp_colour,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic                     wr_sel,
  input  logic [TEX_AW-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic [LANES-1:0]         wr_be
);
  localparam int TEX_WORDS = TEX_BYTES / LANES;
  localparam int TEX_BA_W  = $clog2(TEX_BYTES);
  localparam int OFF_W     = 2 * DIM_W;

  // ---------------- handshakes ----------------
  logic req_fire, wr_fire;
  assign req_ready = rst_n && !upload_en;
  assign wr_ready  = upload_en;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = wr_valid && wr_ready;

  // ---------------- stage 0: cover test and pick ----------------
  logic [N_SPR-1:0] hit_vec, win_oh;
  logic             any_hit;
  logic [DIM_W-1:0] dx_arr [N_SPR];
  logic [DIM_W-1:0] dy_arr [N_SPR];

  for (genvar g = 0; g < N_SPR; g++) begin : g_cover
    spx_cover #(.COORD_W(COORD_W), .DIM_W(DIM_W)) u_cov (
      .valid (spr_valid[g]),
      .x     (req_x),
      .y     (req_y),
      .sx    (spr_x[g*COORD_W +: COORD_W]),
      .sy    (spr_y[g*COORD_W +: COORD_W]),
      .w     (spr_w[g*DIM_W +: DIM_W]),
      .h     (spr_h[g*DIM_W +: DIM_W]),
      .hit   (hit_vec[g]),
      .dx    (dx_arr[g]),
      .dy    (dy_arr[g])
    );
  end

  spx_pick #(.N_SPR(N_SPR)) u_pick (
    .hit_vec (hit_vec),
    .win_oh  (win_oh),
    .any_hit (any_hit)
  );

  // One-hot mux of the winner's fields, then one shared offset multiply.
  logic [DIM_W-1:0]    sel_dx, sel_dy, sel_w;
  logic [PTR_W-1:0]    sel_ptr;
  always_comb begin
    sel_dx  = '0;
    sel_dy  = '0;
    sel_w   = '0;
    sel_ptr = '0;
    for (int i = 0; i < N_SPR; i++) begin
      if (win_oh[i]) begin
        sel_dx  = sel_dx  | dx_arr[i];
        sel_dy  = sel_dy  | dy_arr[i];
        sel_w   = sel_w   | spr_w[i*DIM_W +: DIM_W];
        sel_ptr = sel_ptr | spr_ptr[i*PTR_W +: PTR_W];
      end
    end
  end

  logic [OFF_W-1:0]    offset;
  logic [TEX_BA_W-1:0] byte_addr;
  logic                unused_ptr;
  assign offset    = OFF_W'(sel_dy) * OFF_W'(sel_w) + OFF_W'(sel_dx);
  assign byte_addr = {sel_ptr[TEX_BA_W-1:2], 2'b00} + TEX_BA_W'(offset >> 1);
  assign unused_ptr = ^sel_ptr[PTR_W-1:TEX_BA_W];

  // ---------------- stage 1 registers ----------------
  logic              s1_v, s1_hit, s1_nib;
  logic [TEX_AW-1:0] s1_word;
  logic [1:0]        s1_lane;
  logic [SUB_W-1:0]  s1_sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= req_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire) begin
      s1_hit  <= any_hit;
      s1_word <= byte_addr[TEX_BA_W-1:2];
      s1_lane <= byte_addr[1:0];
      s1_nib  <= offset[0];
      s1_sub  <= sel_ptr[SUB_W-1:0];
    end
  end

  // ---------------- stage 2: texture read ----------------
  logic [WORD_W-1:0] tex_q;

  spx_texmem #(.WORDS(TEX_WORDS), .AW(TEX_AW), .LANES(LANES)) u_tex (
    .clk   (clk),
    .we    (wr_fire && (wr_sel == WR_TEX)),
    .waddr (wr_addr),
    .wdata (wr_data),
    .wbe   (wr_be),
    .re    (s1_v),
    .raddr (s1_word),
    .rdata (tex_q)
  );

  logic             s2_v, s2_hit, s2_nib;
  logic [1:0]       s2_lane;
  logic [SUB_W-1:0] s2_sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
    end else begin
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_v) begin
      s2_hit  <= s1_hit;
      s2_lane <= s1_lane;
      s2_nib  <= s1_nib;
      s2_sub  <= s1_sub;
    end
  end

  // ---------------- stage 3: palette read ----------------
  logic [IDX_W-1:0]  pix_idx;
  logic [COL_W-1:0]  pal_q;
  assign pix_idx = texel_of(tex_q, s2_lane, s2_nib);

  spx_palram #(.DEPTH(PAL_DEPTH), .AW(PAL_AW), .DW(COL_W)) u_pal (
    .clk   (clk),
    .we    (wr_fire && (wr_sel == WR_PAL)),
    .waddr (wr_addr[PAL_AW-1:0]),
    .wdata (wr_data[COL_W-1:0]),
    .re    (s2_v),
    .raddr ({s2_sub, pix_idx}),
    .rdata (pal_q)
  );

  logic s3_v, s3_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_v <= 1'b0;
    end else begin
      s3_v <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_v) s3_hit <= s2_hit;
  end

  assign resp_valid  = s3_v;
  assign resp_colour = s3_hit ? pal_q : BG_COLOUR;
endmodule

// File: rtl/spr_pix_lookup_chk.sv
module spr_pix_lookup_chk #(
  parameter int N_SPR = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upload_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             wr_ready,
  input logic [N_SPR-1:0] hit_vec,
  input logic [N_SPR-1:0] win_oh
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_REQ_CLOSED_IN_UPLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    upload_en |-> !req_ready); // R1

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (resp_valid == $past(req_valid && req_ready, 3))); // R2

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> !resp_valid); // R11

  AST_WR_CLOSED_OUTSIDE_UPLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !upload_en |-> !wr_ready); // R10

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((|win_oh) == (|hit_vec))); // R4

  for (genvar g = 0; g < N_SPR; g++) begin : g_low
    localparam logic [N_SPR-1:0] LOWER = N_SPR'((64'd1 << g) - 64'd1);
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      win_oh[g] |-> (hit_vec[g] && ((hit_vec & LOWER) == '0))); // R4
  end
endmodule

bind spr_pix_lookup spr_pix_lookup_chk #(.N_SPR(N_SPR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upload_en  (upload_en),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .wr_ready   (wr_ready),
  .hit_vec    (hit_vec),
  .win_oh     (win_oh)
);

// File: tb/sim_spr_pix_lookup.sv
module sim_spr_pix_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int CW = 10;
  localparam int DW = 8;
  localparam int TB = 16384;
  localparam logic [15:0] BG = 16'h0421;

  logic clk = 1'b0;
  logic rst_n, upload_en, req_valid, wr_valid, wr_sel;
  logic [CW-1:0] req_x, req_y;
  logic [NS-1:0] spr_valid;
  logic [NS*CW-1:0] spr_x, spr_y;
  logic [NS*DW-1:0] spr_w, spr_h;
  logic [NS*16-1:0] spr_ptr;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_be;
  logic req_ready, resp_valid, wr_ready;
  logic [15:0] resp_colour;

  spr_pix_lookup #(.N_SPR(NS), .COORD_W(CW), .DIM_W(DW), .TEX_BYTES(TB), .BG_COLOUR(BG)) u0 (
    .clk(clk), .rst_n(rst_n), .upload_en(upload_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_x(req_x), .req_y(req_y),
    .spr_valid(spr_valid), .spr_x(spr_x), .spr_y(spr_y), .spr_w(spr_w), .spr_h(spr_h),
    .spr_ptr(spr_ptr), .resp_valid(resp_valid), .resp_colour(resp_colour),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  texb [TB];
  logic [15:0] palm [64];
  int cv [NS], cx [NS], cy [NS], cw [NS], ch [NS], cp [NS];
  int          q_cyc [$];
  logic [15:0] q_col [$];
  string       q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Response monitor: every accepted request is due exactly 3 cycles later (R2).
  always @(negedge clk) begin
    if (rst_n) begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        if (!resp_valid) chk(1'b0, "R2", "missing response", 0, 1);
        else chk(resp_colour == q_col[0], q_tag[0], "colour", int'(resp_colour), int'(q_col[0]));
        void'(q_cyc.pop_front());
        void'(q_col.pop_front());
        void'(q_tag.pop_front());
      end else if (resp_valid) begin
        chk(1'b0, "R2", "unexpected response", 1, 0);
      end
    end
  end

  // Expected colour from R3..R8.
  task automatic expect_px(input int x, input int y, output logic [15:0] col, output string tag);
    int n = 0;
    col = BG;
    for (int i = 0; i < NS; i++) begin
      if (cv[i] != 0 && x >= cx[i] && x < cx[i] + cw[i] && y >= cy[i] && y < cy[i] + ch[i]) begin
        if (n == 0) begin
          int off, ba, idx;
          off = (y - cy[i]) * cw[i] + (x - cx[i]);
          ba  = ((cp[i] & 32'hFFFC) + off / 2) % TB;
          idx = (off % 2 == 1) ? int'(texb[ba][7:4]) : int'(texb[ba][3:0]);
          col = palm[(cp[i] & 3) * 16 + idx];
        end
        n++;
      end
    end
    tag = (n == 0) ? "R5" : (n > 1) ? "R4" : "R3/R6/R7/R8";
  endtask

  task automatic apply_cfg();
    for (int i = 0; i < NS; i++) begin
      spr_valid[i]          = (cv[i] != 0);
      spr_x[i*CW +: CW]     = CW'(cx[i]);
      spr_y[i*CW +: CW]     = CW'(cy[i]);
      spr_w[i*DW +: DW]     = DW'(cw[i]);
      spr_h[i*DW +: DW]     = DW'(ch[i]);
      spr_ptr[i*16 +: 16]   = 16'(cp[i]);
    end
  endtask

  task automatic set_spr(input int i, input int v, input int x, input int y,
                         input int w, input int h, input int p);
    cv[i] = v; cx[i] = x; cy[i] = y; cw[i] = w; ch[i] = h; cp[i] = p;
  endtask

  task automatic issue(input int x, input int y, input string tag_ovr);
    logic [15:0] col;
    string tag;
    @(negedge clk);
    req_valid = 1'b1;
    req_x = CW'(x);
    req_y = CW'(y);
    if (req_ready) begin
      expect_px(x, y, col, tag);
      if (tag_ovr != "") tag = tag_ovr;
      q_cyc.push_back(cyc + 3);
      q_col.push_back(col);
      q_tag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic sweep();
    for (int y = 0; y < 12; y++) begin
      for (int x = 0; x < 80; x++) begin
        if ((x + 3 * y) % 5 == 4) idle(1);
        issue(x, y, "");
      end
    end
    idle(6);
  endtask

  task automatic do_write(input logic sel, input int addr, input logic [31:0] d,
                          input logic [3:0] be, input bit exp_acc, input string tag);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = sel;
    wr_addr  = 12'(addr);
    wr_data  = d;
    wr_be    = be;
    chk(wr_ready == exp_acc, tag, "wr_ready", int'(wr_ready), int'(exp_acc));
    if (wr_ready) begin
      if (sel == 1'b0) begin
        for (int b = 0; b < 4; b++) if (be[b]) texb[addr * 4 + b] = d[b*8 +: 8];
      end else begin
        palm[addr % 64] = d[15:0];
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; upload_en = 1'b0; req_valid = 1'b0; req_x = '0; req_y = '0;
    wr_valid = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
    spr_valid = '0; spr_x = '0; spr_y = '0; spr_w = '0; spr_h = '0; spr_ptr = '0;

    repeat (5) @(negedge clk);
    chk(resp_valid == 1'b0, "R11", "resp_valid in reset", int'(resp_valid), 0);
    chk(req_ready == 1'b0, "R1", "req_ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(wr_ready == 1'b0, "R9", "wr_ready idle", int'(wr_ready), 0);
    chk(resp_valid == 1'b0, "R11", "resp_valid after reset", int'(resp_valid), 0);

    // Upload mode: requests refused (R1), writes taken (R9).
    upload_en = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "req_ready in upload", int'(req_ready), 0);
    chk(wr_ready == 1'b1, "R9", "wr_ready in upload", int'(wr_ready), 1);
    issue(3, 3, "R1");
    issue(4, 3, "R1");
    idle(4);

    for (int w = 0; w < TB / 4; w++) begin
      logic [31:0] d;
      for (int b = 0; b < 4; b++) begin
        int a;
        a = w * 4 + b;
        d[b*8 +: 8] = 8'((a * 13 + (a >> 7) + 7) & 255);
      end
      do_write(1'b0, w, d, 4'hF, 1'b1, "R9");
    end
    for (int k = 0; k < 64; k++) do_write(1'b1, k, {16'hDEAD, 16'(k * 16'h0A51 + 16'h1357)}, 4'h0, 1'b1, "R9");
    do_write(1'b0, 'h40, 32'hA5B6_C7D8, 4'b0101, 1'b1, "R9");   // partial byte enables
    @(negedge clk);
    wr_valid = 1'b0;
    upload_en = 1'b0;

    // Writes outside upload are refused and change nothing (R10).
    do_write(1'b1, 'h1B, 32'h0000_FFFF, 4'hF, 1'b0, "R10");
    do_write(1'b0, 'h80, 32'h1111_1111, 4'hF, 1'b0, "R10");
    @(negedge clk);
    wr_valid = 1'b0;

    // Config A: overlap, masked full-cover entry, pointer that wraps.
    set_spr(0, 1, 5, 2, 7, 4, 'h0102);
    set_spr(1, 1, 9, 0, 20, 9, 'h0201);
    set_spr(2, 0, 0, 0, 80, 12, 'h0003);
    set_spr(3, 1, 40, 3, 1, 1, 'hC013);
    apply_cfg();
    issue(9, 0, "R10");   // reads palette 0x1B and texture word 0x80
    issue(6, 2, "R9");    // reads byte written with partial enables
    idle(6);
    sweep();

    // Config B: full-cover entry under higher-priority ones, odd width, top-of-memory wrap.
    set_spr(0, 1, 60, 5, 33, 6, 'h3FF1);
    set_spr(1, 1, 2, 1, 3, 10, 'h0800);
    set_spr(2, 1, 0, 0, 80, 12, 'h1002);
    set_spr(3, 1, 1, 1, 50, 5, 'h2003);
    apply_cfg();
    sweep();

    // Config C: every entry masked, background everywhere.
    for (int i = 0; i < NS; i++) cv[i] = 0;
    apply_cfg();
    sweep();

    chk(q_cyc.size() == 0, "R2", "outstanding responses", q_cyc.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule